// File: doc/BRIEF.md
# Logarithmic Margin Slew Engine

This block walks a DAC code from one margin code to the other along a geometric path rather than in fixed increments. A single start pulse names the direction. An upward move begins at the low margin code and ends at the high margin code. A downward move begins at the high margin code and ends at the low one. At every step interval the code grows or shrinks by one thirty-second of its present value, so the relative change per step stays near 3.125 %. A low margin of zero would never grow, so an upward move from zero begins at code 1 instead.

Upward and downward moves each take their step interval from their own 3-bit select. Both selects index the same eight-entry table of intervals, which runs from 4 µs to about 5.1 ms per step. The interval is counted in cycles of the block's own clock, and the clock rate is a parameter. A step that would reach or pass the target lands exactly on it. On that step the engine goes idle and gives a one-cycle done pulse.

Top module: `lgs_log_slew`

## Requirements
- R1: A synchronous active-high reset, applied at any time including during a move, leaves code at 0 with busy and done low on the cycle after it is sampled.
- R2: A start pulse sampled while idle sets busy on the next clock edge. On that same edge the code loads a start value: for an upward move (direction input 1) it is the low margin, or 1 if the low margin is 0; for a downward move (direction input 0) it is the high margin.
- R3: Each upward step replaces the code c with c + max(1, c >> 5).
- R4: Each downward step replaces the code c with c − max(1, c >> 5).
- R5: An upward step whose result is at or above the high margin, or a downward step whose result would be at or below the low margin, sets the code to that margin. On the same edge busy falls and done rises, and done stays high for exactly one cycle.
- R6: The first step lands N cycles after the start edge and each later step lands N cycles after the one before it, with the code held in between. N = floor(T × CLK_KHZ / 1000). T in µs is taken from the select value: 0→4, 1→12, 2→27.04, 3→60.72, 4→136.72, 5→418.64, 6→1282, 7→5127.92. N is at least 1. Upward moves use the rise select and downward moves use the fall select.
- R7: A start pulse while busy is ignored. The margin codes and both selects are sampled only when a start is accepted, so changes to them during a move have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse, accepted only while idle |
| dir_up_i | input | 1 | 1 = move from low margin to high, 0 = high to low |
| low_code_i | input | CODE_W | Low margin code |
| high_code_i | input | CODE_W | High margin code |
| rise_sel_i | input | 3 | Interval select for upward moves |
| fall_sel_i | input | 3 | Interval select for downward moves |
| code_o | output | CODE_W | Present DAC code |
| busy_o | output | 1 | High while a move is in progress |
| done_o | output | 1 | One-cycle pulse when the target is reached |

## Verification
On every cycle the assertions check four things: that every code change during a move is exactly one geometric step in the latched direction, that done comes only as busy falls and never lasts two cycles, and that reset leaves the engine idle at code 0. A restart while busy would show up as an illegal jump under the step check. The interval timing per select, the choice between the rise and fall tables, the zero-to-one start substitution and the exact clamp values can only be shown by the bench's scenarios. These compare the code against a model at the cycle just before and the cycle just after every step.

// File: rtl/lgs_pkg.sv
package lgs_pkg;

  localparam int RATE_SEL_W = 3;
  localparam int NUM_RATES  = 1 << RATE_SEL_W;
  localparam int STEP_SHIFT_DEF = 5;

  typedef logic [RATE_SEL_W-1:0] rate_sel_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SLEW = 1'b1
  } slew_state_e;

  // Step interval in hundredths of a microsecond for each select value.
  function automatic longint interval_cs(input int sel);
    case (sel)
      0:       return 64'd400;
      1:       return 64'd1200;
      2:       return 64'd2704;
      3:       return 64'd6072;
      4:       return 64'd13672;
      5:       return 64'd41864;
      6:       return 64'd128200;
      7:       return 64'd512792;
      default: return 64'd400;
    endcase
  endfunction

  // Interval in clock cycles, floored, never below one.
  function automatic longint rate_cycles(input int sel, input int clk_khz);
    longint c;
    c = (interval_cs(sel) * longint'(clk_khz)) / 64'd100000;
    return (c < 64'd1) ? 64'd1 : c;
  endfunction

  // Counter width that can hold the longest interval.
  function automatic int cnt_width(input int clk_khz);
    longint m;
    int     w;
    m = rate_cycles(NUM_RATES - 1, clk_khz);
    w = 1;
    while ((longint'(1) << w) <= m) w++;
    return w;
  endfunction

endpackage

// File: rtl/lgs_rate_rom.sv
module lgs_rate_rom #(
  parameter int CLK_KHZ = 25000,
  parameter int CNT_W   = 17
) (
  input  lgs_pkg::rate_sel_t sel_i,
  output logic [CNT_W-1:0]   cycles_o
);

  logic [CNT_W-1:0] tbl [lgs_pkg::NUM_RATES];

  // One constant entry per select code, computed from the clock rate.
  for (genvar g = 0; g < lgs_pkg::NUM_RATES; g++) begin : g_entry
    assign tbl[g] = CNT_W'(lgs_pkg::rate_cycles(g, CLK_KHZ));
  end

  assign cycles_o = tbl[sel_i];

endmodule

// File: rtl/lgs_interval_timer.sv
module lgs_interval_timer #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             tick_o
);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (load_i) begin
      count_q <= reload_i - CNT_W'(1);
    end else if (run_i) begin
      if (count_q == '0) count_q <= reload_i - CNT_W'(1);
      else               count_q <= count_q - CNT_W'(1);
    end
  end

  assign tick_o = run_i && (count_q == '0);

endmodule

// File: rtl/lgs_step_calc.sv
module lgs_step_calc #(
  parameter int CODE_W = 12,
  parameter int SHIFT  = 5
) (
  input  logic [CODE_W-1:0] cur_i,
  input  logic [CODE_W-1:0] target_i,
  input  logic              up_i,
  output logic [CODE_W-1:0] next_o,
  output logic              arrive_o
);

  localparam int WW = CODE_W + 1;

  logic [WW-1:0] wide_cur;
  logic [WW-1:0] wide_tgt;
  logic [WW-1:0] delta;
  logic [WW-1:0] sum;
  logic [WW-1:0] floor_lim;

  always_comb begin
    wide_cur  = {1'b0, cur_i};
    wide_tgt  = {1'b0, target_i};
    delta     = wide_cur >> SHIFT;
    if (delta == '0) delta = WW'(1);
    sum       = wide_cur + delta;
    floor_lim = wide_tgt + delta;
    if (up_i) begin
      arrive_o = (sum >= wide_tgt);
      next_o   = arrive_o ? target_i : sum[CODE_W-1:0];
    end else begin
      arrive_o = (wide_cur <= floor_lim);
      next_o   = arrive_o ? target_i : (cur_i - delta[CODE_W-1:0]);
    end
  end

endmodule

// File: rtl/lgs_log_slew.sv
module lgs_log_slew #(
  parameter int CODE_W     = 12,
  parameter int CLK_KHZ    = 25000,
  parameter int STEP_SHIFT = lgs_pkg::STEP_SHIFT_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              dir_up_i,
  input  logic [CODE_W-1:0] low_code_i,
  input  logic [CODE_W-1:0] high_code_i,
  input  logic [2:0]        rise_sel_i,
  input  logic [2:0]        fall_sel_i,
  output logic [CODE_W-1:0] code_o,
  output logic              busy_o,
  output logic              done_o
);

  import lgs_pkg::*;

  localparam int CNT_W = cnt_width(CLK_KHZ);

  slew_state_e       state_q;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] target_q;
  logic              dir_q;
  rate_sel_t         sel_q;
  logic              done_q;

  logic              accept;
  rate_sel_t         rate_sel;
  logic [CNT_W-1:0]  reload;
  logic              tick;
  logic [CODE_W-1:0] next_code;
  logic              arrive;
  logic [CODE_W-1:0] start_code;

  assign accept   = (state_q == ST_IDLE) && start_i;
  assign rate_sel = (state_q == ST_IDLE) ? (dir_up_i ? rise_sel_i : fall_sel_i) : sel_q;

  always_comb begin
    if (dir_up_i) start_code = (low_code_i == '0) ? CODE_W'(1) : low_code_i;
    else          start_code = high_code_i;
  end

  lgs_rate_rom #(
    .CLK_KHZ (CLK_KHZ),
    .CNT_W   (CNT_W)
  ) u_rom (
    .sel_i    (rate_sel),
    .cycles_o (reload)
  );

  lgs_interval_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load_i   (accept),
    .run_i    (state_q == ST_SLEW),
    .reload_i (reload),
    .tick_o   (tick)
  );

  lgs_step_calc #(
    .CODE_W (CODE_W),
    .SHIFT  (STEP_SHIFT)
  ) u_step (
    .cur_i    (code_q),
    .target_i (target_q),
    .up_i     (dir_q),
    .next_o   (next_code),
    .arrive_o (arrive)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      code_q   <= '0;
      target_q <= '0;
      dir_q    <= 1'b0;
      sel_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            code_q   <= start_code;
            target_q <= dir_up_i ? high_code_i : low_code_i;
            dir_q    <= dir_up_i;
            sel_q    <= rate_sel;
            state_q  <= ST_SLEW;
          end
        end
        ST_SLEW: begin
          if (tick) begin
            code_q <= next_code;
            if (arrive) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign code_o = code_q;
  assign busy_o = (state_q == ST_SLEW);
  assign done_o = done_q;

endmodule

// File: rtl/lgs_log_slew_chk.sv
module lgs_log_slew_chk #(
  parameter int CODE_W     = 12,
  parameter int STEP_SHIFT = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              dir_up_i,
  input logic [CODE_W-1:0] code_o,
  input logic              busy_o,
  input logic              done_o
);

  logic dir_s;
  logic rst_q = 1'b0;

  function automatic logic [CODE_W:0] stp(input logic [CODE_W-1:0] c);
    logic [CODE_W:0] d;
    d = {1'b0, c} >> STEP_SHIFT;
    return (d == '0) ? (CODE_W+1)'(1) : d;
  endfunction

  // Direction of the move in progress, taken at the ports when a start is accepted.
  always_ff @(posedge clk) begin
    if (rst)                   dir_s <= 1'b0;
    else if (start_i && !busy_o) dir_s <= dir_up_i;
  end

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      a_reset_idle_r1: assert (code_o == '0 && !busy_o && !done_o)
        else $error("R1: state not cleared after reset");
    end
  end

  // R3 (and R7: a restart would show as an illegal jump)
  p_up_step_r3: assert property (@(posedge clk) disable iff (rst)
    busy_o && $past(busy_o) && dir_s && (code_o != $past(code_o))
    |-> ({1'b0, code_o} == {1'b0, $past(code_o)} + stp($past(code_o))));

  // R4
  p_down_step_r4: assert property (@(posedge clk) disable iff (rst)
    busy_o && $past(busy_o) && !dir_s && (code_o != $past(code_o))
    |-> ({1'b0, code_o} + stp($past(code_o)) == {1'b0, $past(code_o)}));

  // R5
  p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  // R5
  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

bind lgs_log_slew lgs_log_slew_chk #(
  .CODE_W     (CODE_W),
  .STEP_SHIFT (STEP_SHIFT)
) u_chk (.*);

// File: tb/tb_lgs_log_slew.sv
module tb_lgs_log_slew;

  localparam int W = 12;
  localparam int KHZ = 1000;
  // Cycles per step at 1 MHz: floor of the microsecond interval.
  localparam int NCYC [8] = '{4, 12, 27, 60, 136, 418, 1282, 5127};

  typedef struct packed {
    logic         up;
    logic [W-1:0] lo;
    logic [W-1:0] hi;
    logic [2:0]   rs;
    logic [2:0]   fs;
    logic [W-1:0] fin;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'd0,    12'd40,   3'd0, 3'd0, 12'd40},
    '{1'b1, 12'd1000, 12'd1400, 3'd1, 3'd0, 12'd1400},
    '{1'b0, 12'd100,  12'd4095, 3'd0, 3'd2, 12'd100},
    '{1'b1, 12'd0,    12'd4095, 3'd0, 3'd5, 12'd4095},
    '{1'b0, 12'd0,    12'd50,   3'd0, 3'd3, 12'd0},
    '{1'b1, 12'd2000, 12'd2000, 3'd0, 3'd0, 12'd2000},
    '{1'b0, 12'd500,  12'd520,  3'd0, 3'd4, 12'd500},
    '{1'b1, 12'd300,  12'd320,  3'd5, 3'd0, 12'd320},
    '{1'b1, 12'd10,   12'd13,   3'd6, 3'd0, 12'd13},
    '{1'b0, 12'd95,   12'd100,  3'd0, 3'd7, 12'd95},
    '{1'b0, 12'd200,  12'd210,  3'd7, 3'd0, 12'd200},
    '{1'b1, 12'd200,  12'd210,  3'd0, 3'd7, 12'd210},
    '{1'b1, 12'd50,   12'd30,   3'd0, 3'd0, 12'd30}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic         dir_up_i = 1'b0;
  logic [W-1:0] low_code_i = '0;
  logic [W-1:0] high_code_i = '0;
  logic [2:0]   rise_sel_i = '0;
  logic [2:0]   fall_sel_i = '0;
  logic [W-1:0] code_o;
  logic         busy_o;
  logic         done_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lgs_log_slew #(.CODE_W(W), .CLK_KHZ(KHZ)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .dir_up_i(dir_up_i),
    .low_code_i(low_code_i), .high_code_i(high_code_i),
    .rise_sel_i(rise_sel_i), .fall_sel_i(fall_sel_i),
    .code_o(code_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int step_of(input int c);
    return ((c >> 5) == 0) ? 1 : (c >> 5);
  endfunction

  task automatic run_slew(input vec_t v, input bit inject);
    int cur, tgt, n, nxt;
    bit arr;
    @(negedge clk);
    dir_up_i = v.up; low_code_i = v.lo; high_code_i = v.hi;
    rise_sel_i = v.rs; fall_sel_i = v.fs; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cur = v.up ? ((v.lo == 0) ? 1 : int'(v.lo)) : int'(v.hi);
    tgt = v.up ? int'(v.hi) : int'(v.lo);
    n   = v.up ? NCYC[v.rs] : NCYC[v.fs];
    chk(code_o == W'(cur), "R2 start code", code_o, cur);
    chk(busy_o == 1'b1, "R2 busy", busy_o, 1);
    for (int k = 0; k < 2000; k++) begin
      for (int c = 0; c < n - 1; c++) begin
        @(negedge clk);
        if (inject && k == 3 && c == 0) begin
          start_i = 1'b1; dir_up_i = ~v.up;
          low_code_i = 12'd7; high_code_i = 12'd9;
          rise_sel_i = 3'd7; fall_sel_i = 3'd7;
        end else if (inject && k == 3 && c == 1) begin
          start_i = 1'b0;
        end
      end
      chk(code_o == W'(cur), "R6 hold before step", code_o, cur);
      if (inject && k == 3) chk(busy_o == 1'b1, "R7 busy kept", busy_o, 1);
      @(negedge clk);
      if (v.up) begin
        nxt = cur + step_of(cur);
        arr = (nxt >= tgt);
      end else begin
        nxt = cur - step_of(cur);
        arr = (cur <= tgt + step_of(cur));
      end
      if (arr) nxt = tgt;
      chk(code_o == W'(nxt), v.up ? "R3 up step" : "R4 down step", code_o, nxt);
      cur = nxt;
      if (arr) begin
        chk(busy_o == 1'b0 && done_o == 1'b1, "R5 done edge", {busy_o, done_o}, 1);
        chk(code_o == v.fin, "R5 final code", code_o, v.fin);
        @(negedge clk);
        chk(done_o == 1'b0, "R5 done one cycle", done_o, 0);
        break;
      end else begin
        chk(busy_o == 1'b1 && done_o == 1'b0, "R6 mid-move flags", {busy_o, done_o}, 2);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end (got 0 expected 1)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(code_o == '0 && !busy_o && !done_o, "R1 reset state", {code_o, busy_o, done_o}, 0);

    for (int i = 0; i < NV; i++) run_slew(VECS[i], 1'b0);

    // R7: restart attempt and input changes mid-move are ignored
    run_slew('{1'b1, 12'd0, 12'd40, 3'd0, 3'd0, 12'd40}, 1'b1);
    run_slew('{1'b0, 12'd600, 12'd800, 3'd0, 3'd0, 12'd600}, 1'b1);

    // R1: reset during a move
    @(negedge clk);
    dir_up_i = 1'b1; low_code_i = '0; high_code_i = 12'd4095;
    rise_sel_i = 3'd0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (50) @(negedge clk);
    chk(busy_o == 1'b1, "R1 busy before reset", busy_o, 1);
    rst = 1'b1;
    @(negedge clk);
    chk(code_o == '0 && !busy_o && !done_o, "R1 reset mid-move", {code_o, busy_o, done_o}, 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk(code_o == '0 && !busy_o, "R1 stays idle", {code_o, busy_o}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule